// File: doc/BRIEF.md
# Inter-processor command mailbox

This block lets a host processor hand work to an I/O coprocessor through three registers. The host writes the address of a command structure into a request pointer register and rings a doorbell bit in a shared flag register. The coprocessor gets a request-pending interrupt, acknowledges by clearing the doorbell, and later posts a completion. To post a completion it writes a reply pointer (normally the original request address) and sets a reply-ready pattern in the same flag register. This raises a reply-ready interrupt to the host, which the host clears by writing ones to those bits.

Each processor has its own simple register port. A write is a single-cycle strobe with an address and data. Read data is combinational on the port's address. The register window decodes only the low ten address bits, so it repeats every 0x400 bytes across the whole 15-bit port address space (0x0000 to 0x7FFF, which includes the 0x6000-byte control range).

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, all three registers read zero on both ports and both interrupts are low.
- R2: A host write to offset 0x0 stores the request pointer with bits [1:0] forced to zero, and both ports read the stored value. A coprocessor write to 0x0 leaves it unchanged.
- R3: A coprocessor write to offset 0x8 stores the reply pointer with bits [1:0] forced to zero, and both ports read the stored value. A host write to 0x8 leaves it unchanged.
- R4: Flag register at offset 0x4, doorbell bit 0:
  - A host write with data bit 0 = 1 sets bit 0. A host write with data bit 0 = 0 leaves bit 0 unchanged.
  - `c_irq` is high exactly while bit 0 is set.
  - A coprocessor write with data bit 0 = 1 clears bit 0.
- R5: Flag register reply-ready bits 2 and 4 (pattern 0x14):
  - A coprocessor write with 1 in bit 2 and/or bit 4 sets those bits. Host writes never set them.
  - `h_irq` is high exactly while bit 2 or bit 4 is set.
  - A host write with 1 in bit 2 or bit 4 clears that bit.
  - Only flag bits 0, 2 and 4 can read as one.
- R6: When both ports write the flag register in the same cycle, their set and clear effects on different bits are merged. For the same bit, the clear wins.
- R7: Address bits [14:10] are ignored, so every register is reached at any address whose bits [9:2] match its offset.
- R8: Offsets 0xC to 0x3FC read zero on both ports, and writes to them change no register.
- R9: Read data follows the port address in the same cycle. A write becomes visible in the cycle after the clock edge that captures it; during the write cycle the old value is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | 15 | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data (combinational) |
| c_wr | input | 1 | Coprocessor write strobe |
| c_addr | input | 15 | Coprocessor byte address |
| c_wdata | input | 32 | Coprocessor write data |
| c_rdata | output | 32 | Coprocessor read data (combinational) |
| c_irq | output | 1 | Request-pending interrupt to the coprocessor |
| h_irq | output | 1 | Reply-ready interrupt to the host |

## Verification
Every register and interrupt changes at the clock edge that captures a write, so the bench drives strobes on the falling edge. It checks read data and interrupts on the next falling edge, one edge after the capture. Read data needs no extra cycle: each read check sets the address and samples one nanosecond later within the low phase. One check samples while a write is still being presented, to confirm the old value is returned until the capturing edge.

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int ADDR_W   = 15,
  parameter int WIN_W    = 10,
  parameter int DATA_W   = 32,
  parameter logic [DATA_W-1:0] DOORBELL = 'h1,
  parameter logic [DATA_W-1:0] REPLY    = 'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  input  logic              c_wr,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [DATA_W-1:0] c_wdata,
  output logic [DATA_W-1:0] c_rdata,
  output logic              c_irq,
  output logic              h_irq
);
  localparam int OFF_W = WIN_W - 2;
  localparam logic [OFF_W-1:0] OFF_REQ = OFF_W'(0);
  localparam logic [OFF_W-1:0] OFF_FLG = OFF_W'(1);
  localparam logic [OFF_W-1:0] OFF_RPL = OFF_W'(2);
  localparam logic [DATA_W-1:0] ALIGN = ~DATA_W'(3);

  logic [OFF_W-1:0]  h_off, c_off;
  logic [DATA_W-1:0] req_ptr, rpl_ptr, flags, flags_nxt;
  logic [DATA_W-1:0] set_bits, clr_bits;
  logic              h_flg_wr, c_flg_wr;
  logic              unused_bits;

  assign h_off = h_addr[WIN_W-1:2];
  assign c_off = c_addr[WIN_W-1:2];
  assign unused_bits = ^{h_addr[ADDR_W-1:WIN_W], h_addr[1:0],
                         c_addr[ADDR_W-1:WIN_W], c_addr[1:0]};

  assign h_flg_wr = h_wr && h_off == OFF_FLG;
  assign c_flg_wr = c_wr && c_off == OFF_FLG;

  assign set_bits  = ({DATA_W{h_flg_wr}} & h_wdata & DOORBELL)
                   | ({DATA_W{c_flg_wr}} & c_wdata & REPLY);
  assign clr_bits  = ({DATA_W{h_flg_wr}} & h_wdata & REPLY)
                   | ({DATA_W{c_flg_wr}} & c_wdata & DOORBELL);
  assign flags_nxt = (flags | set_bits) & ~clr_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_ptr <= '0;
      rpl_ptr <= '0;
      flags   <= '0;
    end else begin
      if (h_wr && h_off == OFF_REQ) req_ptr <= h_wdata & ALIGN;
      if (c_wr && c_off == OFF_RPL) rpl_ptr <= c_wdata & ALIGN;
      flags <= flags_nxt;
    end
  end

  always_comb begin
    case (h_off)
      OFF_REQ: h_rdata = req_ptr;
      OFF_FLG: h_rdata = flags;
      OFF_RPL: h_rdata = rpl_ptr;
      default: h_rdata = '0;
    endcase
  end

  always_comb begin
    case (c_off)
      OFF_REQ: c_rdata = req_ptr;
      OFF_FLG: c_rdata = flags;
      OFF_RPL: c_rdata = rpl_ptr;
      default: c_rdata = '0;
    endcase
  end

  assign c_irq = |(flags & DOORBELL);
  assign h_irq = |(flags & REPLY);

  AST_REQ_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(h_wr && h_off == OFF_REQ) |-> $stable(req_ptr)); // R2
  AST_RPL_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(c_wr && c_off == OFF_RPL) |-> $stable(rpl_ptr)); // R3
  AST_CIRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(c_irq) |-> $past(h_wr && h_off == OFF_FLG && h_wdata[0])); // R4
  AST_HIRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(h_irq) |-> $past(h_wr && h_off == OFF_FLG && (h_wdata & REPLY) != '0)); // R5
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_off == OFF_FLG && h_wdata[0] && c_wr && c_off == OFF_FLG && c_wdata[0])
    |=> !c_irq); // R6
  AST_FLAG_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rdata & ~(DOORBELL | REPLY)) == '0 || h_off != OFF_FLG); // R5
endmodule

// File: tb/ipc_mailbox_bench.sv
`timescale 1ns/1ps
module ipc_mailbox_bench;
  logic        clk = 0, rst_n = 0;
  logic        h_wr = 0, c_wr = 0;
  logic [14:0] h_addr = 0, c_addr = 0;
  logic [31:0] h_wdata = 0, c_wdata = 0;
  logic [31:0] h_rdata, c_rdata;
  logic        c_irq, h_irq;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ipc_mailbox u_ipc_mailbox (
    .clk(clk), .rst_n(rst_n),
    .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .c_wr(c_wr), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata),
    .c_irq(c_irq), .h_irq(h_irq));

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic h_write(logic [14:0] a, logic [31:0] d);
    @(negedge clk); h_wr = 1; h_addr = a; h_wdata = d;
    @(negedge clk); h_wr = 0;
  endtask

  task automatic c_write(logic [14:0] a, logic [31:0] d);
    @(negedge clk); c_wr = 1; c_addr = a; c_wdata = d;
    @(negedge clk); c_wr = 0;
  endtask

  task automatic both_write(logic [14:0] ha, logic [31:0] hd, logic [14:0] ca, logic [31:0] cd);
    @(negedge clk); h_wr = 1; h_addr = ha; h_wdata = hd; c_wr = 1; c_addr = ca; c_wdata = cd;
    @(negedge clk); h_wr = 0; c_wr = 0;
  endtask

  task automatic h_read(logic [14:0] a, output logic [31:0] d);
    h_addr = a; #1; d = h_rdata;
  endtask

  task automatic c_read(logic [14:0] a, output logic [31:0] d);
    c_addr = a; #1; d = c_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int i = 0; i < 3; i++) begin
      h_read(15'(i*4), v); check("R1", "host reset read", v, 0);
      c_read(15'(i*4), v); check("R1", "copro reset read", v, 0);
    end
    check("R1", "c_irq reset", {31'b0, c_irq}, 0);
    check("R1", "h_irq reset", {31'b0, h_irq}, 0);
  endtask

  task automatic t_req_ptr;
    logic [31:0] v;
    @(negedge clk); h_wr = 1; h_addr = 15'h0; h_wdata = 32'h1234_5677;
    #1; check("R9", "old value during write", h_rdata, 0);
    @(negedge clk); h_wr = 0;
    h_read(15'h0, v); check("R2", "host req ptr", v, 32'h1234_5674);
    c_read(15'h0, v); check("R2", "copro req ptr", v, 32'h1234_5674);
    c_write(15'h0, 32'hFFFF_FFFF);
    h_read(15'h0, v); check("R2", "copro write ignored", v, 32'h1234_5674);
  endtask

  task automatic t_rpl_ptr;
    logic [31:0] v;
    c_write(15'h8, 32'hCAFE_0003);
    h_read(15'h8, v); check("R3", "host rpl ptr", v, 32'hCAFE_0000);
    c_read(15'h8, v); check("R3", "copro rpl ptr", v, 32'hCAFE_0000);
    h_write(15'h8, 32'h1111_1110);
    c_read(15'h8, v); check("R3", "host write ignored", v, 32'hCAFE_0000);
  endtask

  task automatic t_doorbell;
    logic [31:0] v;
    h_write(15'h4, 32'h0000_0000);
    check("R4", "zero write no doorbell", {31'b0, c_irq}, 0);
    h_write(15'h4, 32'hFFFF_FFFF);
    c_read(15'h4, v); check("R4", "doorbell set, host cannot set reply", v, 32'h1);
    check("R4", "c_irq high", {31'b0, c_irq}, 1);
    check("R5", "h_irq stays low", {31'b0, h_irq}, 0);
    h_write(15'h4, 32'h0);
    check("R4", "c_irq held", {31'b0, c_irq}, 1);
    c_write(15'h4, 32'h1);
    c_read(15'h4, v); check("R4", "doorbell cleared", v, 0);
    check("R4", "c_irq low", {31'b0, c_irq}, 0);
  endtask

  task automatic t_reply;
    logic [31:0] v;
    c_write(15'h4, 32'hFFFF_FFFE);
    h_read(15'h4, v); check("R5", "reply pattern", v, 32'h14);
    check("R5", "h_irq high", {31'b0, h_irq}, 1);
    check("R5", "c_irq low", {31'b0, c_irq}, 0);
    h_write(15'h4, 32'h4);
    h_read(15'h4, v); check("R5", "partial clear", v, 32'h10);
    check("R5", "h_irq still high", {31'b0, h_irq}, 1);
    h_write(15'h4, 32'h10);
    h_read(15'h4, v); check("R5", "full clear", v, 0);
    check("R5", "h_irq low", {31'b0, h_irq}, 0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    both_write(15'h4, 32'h1, 15'h4, 32'h14);
    h_read(15'h4, v); check("R6", "merge different bits", v, 32'h15);
    both_write(15'h4, 32'h1, 15'h4, 32'h1);
    h_read(15'h4, v); check("R6", "bit0 clear wins", v, 32'h14);
    both_write(15'h4, 32'h14, 15'h4, 32'h14);
    h_read(15'h4, v); check("R6", "reply clear wins", v, 0);
    check("R6", "both irqs low", {30'b0, h_irq, c_irq}, 0);
  endtask

  task automatic t_mirror;
    logic [31:0] v;
    h_write(15'h0400, 32'hA5A5_0000);
    c_read(15'h7C00, v); check("R7", "req ptr via mirror", v, 32'hA5A5_0000);
    c_write(15'h5808, 32'h0BAD_F00C);
    h_read(15'h2008, v); check("R7", "rpl ptr via mirror", v, 32'h0BAD_F00C);
    h_write(15'h2C04, 32'h1);
    check("R7", "doorbell via mirror", {31'b0, c_irq}, 1);
    c_write(15'h6404, 32'h1);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    h_write(15'h00C, 32'hFFFF_FFFF);
    c_write(15'h3FC, 32'hFFFF_FFFF);
    h_write(15'h010, 32'hFFFF_FFFF);
    h_read(15'h00C, v); check("R8", "host read 0xC", v, 0);
    c_read(15'h3FC, v); check("R8", "copro read 0x3FC", v, 0);
    h_read(15'h0, v);   check("R8", "req ptr untouched", v, 32'hA5A5_0000);
    h_read(15'h8, v);   check("R8", "rpl ptr untouched", v, 32'h0BAD_F00C);
    h_read(15'h4, v);   check("R8", "flags untouched", v, 0);
    check("R8", "irqs untouched", {30'b0, h_irq, c_irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_req_ptr;
    t_rpl_ptr;
    t_doorbell;
    t_reply;
    t_collide;
    t_mirror;
    t_unmapped;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule